// File: doc/BRIEF.md
# Disc Subcode Channel Serial Output

This block sends the eight subcode channel bits of every disc frame out on one wire. A host outside the chip clocks the bits with its own read clock. Each frame's subcode symbol reaches the block as one 8-bit value, marked by a one-cycle strobe and tagged with its position inside a 98-symbol block. The block latches the symbol when the strobe arrives and raises a frame sync to tell the host that a fresh symbol is ready. The block then shifts out one bit for each rising edge of the read clock. The order is P first and W last, and a 0 follows W.

A block sync output stays high while the symbol latched last is one of the two sync symbols of a block. These are S0 and S1, at index 0 and 1. Because the read clock is asynchronous, it passes through a synchroniser into the system clock domain before its edges are detected. A new strobe always reloads the shifter. As a result, a host that reads too late never sees bits from two different frames mixed together.

Control is a four-state machine:
- ST_IDLE holds the data line at 0 after reset.
- ST_ARMED holds a latched symbol whose first bit has not yet been read. Frame sync is high in this state.
- ST_SHIFT is entered on the first read edge and is where the P to W bits leave.
- ST_TAIL is entered on the read edge that sends W. Every further edge sends 0.

The state transitions are:
- A strobe moves any state to ST_ARMED.
- A read edge moves ST_ARMED to ST_SHIFT.
- A read edge moves ST_SHIFT to ST_TAIL once W has gone out.
- Read edges keep ST_TAIL in ST_TAIL.
- A read edge in ST_IDLE is ignored.

Top module: `subc_out`

## Requirements
- R1: After reset, frame_sync, block_sync and sub_data are all 0.
- R2: In the cycle after a sym_valid strobe, frame_sync is 1 and sub_data is 0. The symbol is latched at that strobe.
- R3: The first detected rising edge of rd_clk after a strobe clears frame_sync and drives sym_data bit 7 (channel P) onto sub_data.
- R4: Successive detected rising edges of rd_clk drive sym_data bits 7, 6, 5, 4, 3, 2, 1, 0 in that order. These are channels P, Q, R, S, T, U, V, W.
- R5: Each detected rising edge after the one that sent bit 0 drives sub_data to 0. This continues until the next strobe.
- R6: block_sync is set at a strobe to 1 when sym_idx is 0 or 1 and to 0 for any other index. It holds that value until the next strobe.
- R7: rd_clk passes through SYNC_STAGES flops. sub_data changes SYNC_STAGES+1 clock edges after the rd_clk rise. A falling edge, or rd_clk held high, never advances the bit.
- R8: A strobe that arrives part way through a symbol discards the unsent bits. It raises frame_sync again, and the next read edge sends the new symbol's bit 7.
- R9: When a strobe and a detected read edge fall in the same cycle, the strobe wins and the read edge is dropped.
- R10: sub_data changes only at a strobe or at a detected read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_clk | input | 1 | External subcode read clock, asynchronous |
| sym_valid | input | 1 | One-cycle strobe marking a new frame symbol |
| sym_data | input | 8 | Subcode symbol, bit 7 = P to bit 0 = W |
| sym_idx | input | 7 | Symbol position within the 98-symbol block |
| frame_sync | output | 1 | High from the strobe until the first read edge |
| block_sync | output | 1 | High while the latched symbol is S0 or S1 |
| sub_data | output | 1 | Serial subcode bit |

## Verification
A symbol strobe and a synchronised read-clock edge can reach the state machine in the same cycle. The bench provokes this by raising rd_clk and then placing the strobe exactly SYNC_STAGES cycles later, so that both act on the same clock edge. The test passes when three things hold after that edge:
- frame_sync is still high.
- sub_data is 0.
- The next read edge returns the new symbol's P bit, not a bit of the old symbol.

// File: rtl/subc_pkg.sv
package subc_pkg;

    localparam int SUBC_SYM_W       = 8;
    localparam int SUBC_BLK_LEN     = 98;
    localparam int SUBC_SYNC_SYMS   = 2;
    localparam int SUBC_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TAIL  = 2'd3
    } subc_state_t;

endpackage

// File: rtl/subc_sync.sv
module subc_sync #(
    parameter int STAGES = subc_pkg::SUBC_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    logic [STAGES-1:0] chain;
    logic              last_q;

    // Synchroniser chain, one flop per stage
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last_q;

endmodule

// File: rtl/subc_blk.sv
module subc_blk #(
    parameter int BLK_LEN   = subc_pkg::SUBC_BLK_LEN,
    parameter int SYNC_SYMS = subc_pkg::SUBC_SYNC_SYMS,
    localparam int IDX_W    = $clog2(BLK_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] idx,
    output logic             bsync
);

    localparam logic [IDX_W-1:0] SYNC_LIM = IDX_W'(SYNC_SYMS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    bsync <= 1'b0;
        else if (load) bsync <= (idx < SYNC_LIM);
    end

endmodule

// File: rtl/subc_shift.sv
module subc_shift #(
    parameter int SYM_W  = subc_pkg::SUBC_SYM_W,
    localparam int CNT_W = $clog2(SYM_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    input  logic [SYM_W-1:0] sym_in,
    output logic             dout,
    output logic             last_bit
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYM_W - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SYM_W);

    logic [SYM_W-1:0] hold_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            cnt_q  <= '0;
            dout   <= 1'b0;
        end else if (load) begin
            hold_q <= sym_in;
            cnt_q  <= '0;
            dout   <= 1'b0;
        end else if (advance) begin
            // MSB first; zeros fill in behind, so the tail bit is 0
            dout   <= hold_q[SYM_W-1];
            hold_q <= {hold_q[SYM_W-2:0], 1'b0};
            if (cnt_q != CNT_FULL) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_bit = (cnt_q == CNT_LAST);

endmodule

// File: rtl/subc_ctrl.sv
module subc_ctrl
    import subc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic rd_rise,
    input  logic last_bit,
    output logic load,
    output logic advance,
    output logic fsync
);

    subc_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        advance = 1'b0;
        fsync   = (state_q == ST_ARMED);
        if (strobe) begin
            // strobe outranks a coincident read edge
            load    = 1'b1;
            state_d = ST_ARMED;
        end else if (rd_rise) begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_ARMED: begin
                    advance = 1'b1;
                    state_d = ST_SHIFT;
                end
                ST_SHIFT: begin
                    advance = 1'b1;
                    state_d = last_bit ? ST_TAIL : ST_SHIFT;
                end
                ST_TAIL: begin
                    advance = 1'b1;
                    state_d = ST_TAIL;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/subc_out.sv
module subc_out #(
    parameter int SYM_W       = subc_pkg::SUBC_SYM_W,
    parameter int BLK_LEN     = subc_pkg::SUBC_BLK_LEN,
    parameter int SYNC_SYMS   = subc_pkg::SUBC_SYNC_SYMS,
    parameter int SYNC_STAGES = subc_pkg::SUBC_SYNC_STAGES,
    localparam int IDX_W      = $clog2(BLK_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_clk,
    input  logic             sym_valid,
    input  logic [SYM_W-1:0] sym_data,
    input  logic [IDX_W-1:0] sym_idx,
    output logic             frame_sync,
    output logic             block_sync,
    output logic             sub_data
);

    logic rd_rise;
    logic do_load;
    logic do_adv;
    logic last_bit;

    subc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (rd_clk),
        .rise     (rd_rise)
    );

    subc_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (sym_valid),
        .rd_rise  (rd_rise),
        .last_bit (last_bit),
        .load     (do_load),
        .advance  (do_adv),
        .fsync    (frame_sync)
    );

    subc_shift #(.SYM_W(SYM_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (do_load),
        .advance  (do_adv),
        .sym_in   (sym_data),
        .dout     (sub_data),
        .last_bit (last_bit)
    );

    subc_blk #(.BLK_LEN(BLK_LEN), .SYNC_SYMS(SYNC_SYMS)) u_blk (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (do_load),
        .idx   (sym_idx),
        .bsync (block_sync)
    );

endmodule

// File: rtl/subc_out_chk.sv
module subc_out_chk #(
    parameter int IDX_W     = 7,
    parameter int SYNC_SYMS = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sym_valid,
    input logic [IDX_W-1:0] sym_idx,
    input logic             rise,
    input logic             frame_sync,
    input logic             block_sync,
    input logic             sub_data
);

    localparam logic [IDX_W-1:0] LIM = IDX_W'(SYNC_SYMS);

    AST_FSYNC_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |=> frame_sync); // R2

    AST_DATA_ZERO_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |=> !sub_data); // R2

    AST_FSYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_sync && rise && !sym_valid) |=> !frame_sync); // R3

    AST_FSYNC_ONLY_BY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_sync && !sym_valid) |=> !frame_sync); // R2

    AST_BSYNC_FROM_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |=> (block_sync == ($past(sym_idx) < LIM))); // R6

    AST_BSYNC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> $stable(block_sync)); // R6

    AST_DATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!sym_valid && !rise) |=> $stable(sub_data)); // R10

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R7

endmodule

bind subc_out subc_out_chk #(.IDX_W(IDX_W), .SYNC_SYMS(SYNC_SYMS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sym_valid  (sym_valid),
    .sym_idx    (sym_idx),
    .rise       (rd_rise),
    .frame_sync (frame_sync),
    .block_sync (block_sync),
    .sub_data   (sub_data)
);

// File: tb/test_subc_out.sv
`timescale 1ns/1ps
module test_subc_out;

    localparam int SYM_W = 8;
    localparam int IDX_W = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rd_clk = 1'b0;
    logic             sym_valid = 1'b0;
    logic [SYM_W-1:0] sym_data = '0;
    logic [IDX_W-1:0] sym_idx = '0;
    logic             frame_sync;
    logic             block_sync;
    logic             sub_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    subc_out i_subc_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_clk     (rd_clk),
        .sym_valid  (sym_valid),
        .sym_data   (sym_data),
        .sym_idx    (sym_idx),
        .frame_sync (frame_sync),
        .block_sync (block_sync),
        .sub_data   (sub_data)
    );

    function automatic logic exp_bit(logic [SYM_W-1:0] s, int k);
        return (k < SYM_W) ? s[SYM_W-1-k] : 1'b0;
    endfunction

    function automatic logic exp_bsync(logic [IDX_W-1:0] i);
        return (i == 0) || (i == 1);
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic strobe(logic [SYM_W-1:0] d, logic [IDX_W-1:0] i);
        @(negedge clk);
        sym_data  = d;
        sym_idx   = i;
        sym_valid = 1'b1;
        @(negedge clk);
        sym_valid = 1'b0;
        sym_data  = $urandom;
        sym_idx   = IDX_W'($urandom);
    endtask

    task automatic rd_up();
        @(negedge clk);
        rd_clk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic rd_down();
        rd_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [SYM_W-1:0] a;
        logic [SYM_W-1:0] b;
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        check("R1 frame_sync", frame_sync, 1'b0);
        check("R1 block_sync", block_sync, 1'b0);
        check("R1 sub_data", sub_data, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // directed: full symbol, tail zeros, S0 block sync
        a = 8'b1011_0010;
        strobe(a, 7'd0);
        check("R2 frame_sync", frame_sync, 1'b1);
        check("R2 sub_data", sub_data, 1'b0);
        check("R6 idx0", block_sync, 1'b1);
        for (int k = 0; k < 11; k++) begin
            rd_up();
            check(k < 8 ? "R4 bit" : "R5 tail", sub_data, exp_bit(a, k));
            if (k == 0) begin
                check("R3 fsync clear", frame_sync, 1'b0);
                check("R3 P bit", sub_data, a[7]);
                repeat (6) @(negedge clk);
                check("R7 held high", sub_data, a[7]);
            end
            rd_down();
            check("R10 fall ignored", sub_data, exp_bit(a, k));
        end

        // exact synchroniser latency
        strobe(8'hFF, 7'd1);
        check("R6 idx1", block_sync, 1'b1);
        @(negedge clk);
        rd_clk = 1'b1;
        repeat (2) @(negedge clk);
        check("R7 not yet", sub_data, 1'b0);
        @(negedge clk);
        check("R7 after latency", sub_data, 1'b1);
        rd_down();

        // mid-symbol restart
        a = 8'b0110_1001;
        b = 8'b1000_0111;
        strobe(a, 7'd2);
        check("R6 idx2", block_sync, 1'b0);
        for (int k = 0; k < 3; k++) begin rd_up(); rd_down(); end
        strobe(b, 7'd50);
        check("R8 fsync again", frame_sync, 1'b1);
        check("R8 data zero", sub_data, 1'b0);
        rd_up();
        check("R8 new P", sub_data, b[7]);
        rd_down();

        // collision: strobe and read edge on the same clock edge
        @(negedge clk);
        rd_clk = 1'b1;
        @(negedge clk);
        @(negedge clk);
        sym_data  = 8'h7F;
        sym_idx   = 7'd97;
        sym_valid = 1'b1;
        @(negedge clk);
        sym_valid = 1'b0;
        check("R9 fsync kept", frame_sync, 1'b1);
        check("R9 data zero", sub_data, 1'b0);
        check("R6 idx97", block_sync, 1'b0);
        rd_down();
        rd_up();
        check("R9 new P", sub_data, 1'b0);
        rd_down();
        rd_up();
        check("R9 new Q", sub_data, 1'b1);
        rd_down();

        // random frames
        for (int f = 0; f < 60; f++) begin
            logic [SYM_W-1:0] d;
            logic [IDX_W-1:0] ix;
            int nrd;
            d   = SYM_W'($urandom);
            ix  = ($urandom_range(0, 3) == 0) ? IDX_W'($urandom_range(0, 1))
                                               : IDX_W'($urandom_range(0, 97));
            nrd = $urandom_range(0, 11);
            strobe(d, ix);
            check("R2 rnd fsync", frame_sync, 1'b1);
            check("R6 rnd bsync", block_sync, exp_bsync(ix));
            for (int k = 0; k < nrd; k++) begin
                rd_up();
                check("R4 rnd bit", sub_data, exp_bit(d, k));
                check("R3 rnd fsync", frame_sync, 1'b0);
                rd_down();
            end
            check("R6 rnd hold", block_sync, exp_bsync(ix));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule